// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-Up

This block is a watchdog that counts pulses of a slow tick input. The tick comes from the watchdog's own oscillator, which is separate from the core clock, so counting goes on while the core is asleep. The logic runs on the fabric clock `clk`. `tick` is a one-cycle enable in that clock domain. Each tick advances a base counter of `2**CNT_W` states. When the postscaler is assigned to the watchdog, it divides the base wraps by `2**n`, where `n` is the 3-bit ratio select. The longest time-out is therefore 128 base periods.

When the watchdog expires in normal operation, the block sends the reset controller a one-cycle reset request. After a sleep-entry strobe, the block is asleep, and the same expiry raises a one-cycle wake-up request instead. Waking returns the block to normal operation. Both the clear command and the sleep strobe restart the base counter and the postscaler, and they set the time-out status flag back to 1. Any expiry drives that flag to 0. A static enable bit turns the whole watchdog off.

Top module: `wdt_sleep_guard`

## Requirements
- R1: During and immediately after synchronous reset, `rst_req` = 0, `wake_req` = 0 and `to_n` = 1.
- R2: When `ps_on` = 0, the first expiry comes exactly `2**CNT_W` ticks after a clear, whatever `ps_sel` holds. The request lasts exactly one `clk` cycle: it is registered on the edge that samples the final tick.
- R3: When `ps_on` = 1 and `ps_sel` = n (unsigned, 0 to 7), expiry comes exactly `2**CNT_W * 2**n` ticks after a clear.
- R4: A clear command (`clr_cmd` = 1 for one cycle) zeroes the base counter and the postscaler. The next expiry is then a full period after the clear. A clear overrides a tick in the same cycle.
- R5: A sleep strobe (`sleep_cmd`) restarts the count just as a clear does. The next expiry raises `wake_req` and not `rst_req`. It also returns the block to normal operation, so the expiry after that raises `rst_req`.
- R6: `to_n` goes to 0 on the same edge as any request pulse. It returns to 1 on a clear or a sleep strobe.
- R7: While `wdt_en` = 0, no tick count ever produces `rst_req` or `wake_req`, and `to_n` stays at 1.
- R8: `ps_on` and `ps_sel` are sampled only at reset, clear and sleep entry. A change between those events does not alter the running period.
- R9: After an expiry the count restarts from zero. Without any clear, the next expiry follows after another full period.
- R10: `clk` cycles with `tick` = 0 do not advance the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tick | input | 1 | One-cycle pulse from the watchdog oscillator |
| wdt_en | input | 1 | Static enable configuration bit |
| clr_cmd | input | 1 | Clear-watchdog command strobe |
| sleep_cmd | input | 1 | Sleep-entry strobe |
| ps_on | input | 1 | 1 = postscaler divides the watchdog |
| ps_sel | input | SEL_W | Postscaler exponent n (divide by 2**n) |
| rst_req | output | 1 | One-cycle reset request on expiry while awake |
| wake_req | output | 1 | One-cycle wake request on expiry while asleep |
| to_n | output | 1 | Time-out status flag, 0 after an expiry |

## Verification
The main check sweeps `ps_on` and `ps_sel` over every ratio, measures the number of ticks from a clear to the first request, and then measures again without a clear. The unassigned rows with a nonzero `ps_sel` separate a postscaler that gates correctly from one that leaks the select through. The assigned rows catch an off-by-one or a shift error at each exponent. Repeating the measurement without a clear shows whether the counters restart from zero after an expiry. Further directed cases cover a clear in mid-count, a sleep followed by two expiries, a select change without a clear, idle clock cycles with no tick, and the disabled state.

// File: rtl/wdt_sleep_pkg.sv
package wdt_sleep_pkg;

  // Operating state of the watchdog
  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_SLEEP = 1'b1
  } wdt_mode_e;

  // Terminal postscaler count for a divide-by-2**n ratio; 0 when unassigned
  function automatic int unsigned ratio_mask(input logic on, input int unsigned n);
    int unsigned m;
    m = 0;
    if (on) begin
      for (int i = 0; i < 32; i++) begin
        if (i < int'(n)) m[i] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic restart,
  output logic wrap
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !en) cnt_q <= '0;
    else if (tick)             cnt_q <= cnt_q + 1'b1;
  end

  // A restart in the same cycle wins over the final tick
  assign wrap = en & tick & ~restart & (cnt_q == CNT_LAST);

  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (cnt_q == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(restart) && !$past(rst) && $past(en)) |-> $stable(cnt_q));

endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler
  import wdt_sleep_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic             wrap,
  input  logic             ps_on,
  input  logic [SEL_W-1:0] ps_sel,
  output logic             expire
);
  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      ps_q   <= '0;
      mask_q <= PS_W'(ratio_mask(ps_on, int'(ps_sel)));
    end else if (!en) begin
      ps_q <= '0;
    end else if (wrap) begin
      ps_q <= (ps_q == mask_q) ? '0 : ps_q + 1'b1;
    end
  end

  assign expire = wrap & (ps_q == mask_q);

  // R3
  ps_range_chk: assert property (@(posedge clk) disable iff (rst)
    ps_q <= mask_q);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(restart) && !$past(rst)) |-> $stable(mask_q));

endmodule

// File: rtl/wdt_mode_ctl.sv
module wdt_mode_ctl
  import wdt_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sleep_in,
  input  logic expire,
  output logic rst_req,
  output logic wake_req,
  output logic to_n
);
  wdt_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RUN;
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_n     <= 1'b1;
    end else begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      if (sleep_in) begin
        mode_q <= MODE_SLEEP;
        to_n   <= 1'b1;
      end else if (clr) begin
        to_n   <= 1'b1;
      end
      if (expire) begin
        rst_req  <= (mode_q == MODE_RUN);
        wake_req <= (mode_q == MODE_SLEEP);
        to_n     <= 1'b0;
        mode_q   <= MODE_RUN;
      end
    end
  end

  // R5
  excl_req_chk: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && wake_req));

  // R5
  wake_asleep_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(mode_q == MODE_SLEEP));

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_req || wake_req) |=> !(rst_req || wake_req));

  // R6
  to_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(to_n) |-> (rst_req || wake_req));

endmodule

// File: rtl/wdt_sleep_guard.sv
module wdt_sleep_guard #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wdt_en,
  input  logic             clr_cmd,
  input  logic             sleep_cmd,
  input  logic             ps_on,
  input  logic [SEL_W-1:0] ps_sel,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_n
);
  logic restart;
  logic wrap;
  logic expire;

  assign restart = clr_cmd | sleep_cmd;

  wdt_base_counter #(.CNT_W(CNT_W)) u_base (
    .clk     (clk),
    .rst     (rst),
    .en      (wdt_en),
    .tick    (tick),
    .restart (restart),
    .wrap    (wrap)
  );

  wdt_postscaler #(.SEL_W(SEL_W)) u_ps (
    .clk     (clk),
    .rst     (rst),
    .en      (wdt_en),
    .restart (restart),
    .wrap    (wrap),
    .ps_on   (ps_on),
    .ps_sel  (ps_sel),
    .expire  (expire)
  );

  wdt_mode_ctl u_mode (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_cmd),
    .sleep_in (sleep_cmd),
    .expire   (expire),
    .rst_req  (rst_req),
    .wake_req (wake_req),
    .to_n     (to_n)
  );

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wdt_en) |-> (!rst_req && !wake_req));

endmodule

// File: tb/tb_wdt_sleep_guard.sv
module tb_wdt_sleep_guard;
  localparam int CNT_W = 4;
  localparam int SEL_W = 3;
  localparam int BASE  = 1 << CNT_W;
  localparam int NVEC  = 10;
  // {ps_on, ps_sel}
  localparam logic [3:0] VEC_CFG [NVEC] = '{4'h0, 4'h5, 4'h8, 4'h9, 4'hA,
                                            4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
  localparam int VEC_EXP [NVEC] = '{BASE, BASE, BASE, BASE*2, BASE*4,
                                    BASE*8, BASE*16, BASE*32, BASE*64, BASE*128};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wdt_en = 1'b1, clr_cmd = 1'b0, sleep_cmd = 1'b0, ps_on = 1'b0;
  logic [SEL_W-1:0] ps_sel = '0;
  logic rst_req, wake_req, to_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_sleep_guard #(.CNT_W(CNT_W), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wdt_en(wdt_en), .clr_cmd(clr_cmd),
    .sleep_cmd(sleep_cmd), .ps_on(ps_on), .ps_sel(ps_sel),
    .rst_req(rst_req), .wake_req(wake_req), .to_n(to_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr_cmd = 1'b1;
    @(negedge clk) clr_cmd = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk) sleep_cmd = 1'b1;
    @(negedge clk) sleep_cmd = 1'b0;
  endtask

  // One tick, then three idle cycles; the outputs are sampled right after the tick's edge
  task automatic do_tick(output logic r, output logic w);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    r = rst_req;
    w = wake_req;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(input int limit, output int n, output logic r, output logic w);
    n = 0; r = 1'b0; w = 1'b0;
    while (!r && !w && n < limit) begin
      do_tick(r, w);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic r, w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rst_req == 0 && wake_req == 0, "R1 req during reset", int'(rst_req | wake_req), 0);
    chk(to_n == 1, "R1 flag during reset", int'(to_n), 1);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(rst_req == 0 && wake_req == 0 && to_n == 1, "R1 after reset",
        int'({rst_req, wake_req, to_n}), 1);

    // Table walk: R2, R3, R9
    for (int i = 0; i < NVEC; i++) begin
      ps_on  = VEC_CFG[i][3];
      ps_sel = VEC_CFG[i][2:0];
      pulse_clr();
      measure(VEC_EXP[i] + 4, n, r, w);
      chk(r && !w && n == VEC_EXP[i], VEC_CFG[i][3] ? "R3 ratio period" : "R2 base period",
          n, VEC_EXP[i]);
      @(negedge clk);
      chk(rst_req == 0, "R2 one-cycle pulse", int'(rst_req), 0);
      measure(VEC_EXP[i] + 4, n, r, w);
      chk(r && n == VEC_EXP[i], "R9 restart after expiry", n, VEC_EXP[i]);
    end

    // R6 flag low after expiry, high after clear
    chk(to_n == 0, "R6 flag after expiry", int'(to_n), 0);
    ps_on = 1'b0;
    pulse_clr();
    chk(to_n == 1, "R6 flag after clear", int'(to_n), 1);

    // R4 clear mid-count
    for (int k = 0; k < 10; k++) do_tick(r, w);
    pulse_clr();
    measure(BASE + 4, n, r, w);
    chk(r && n == BASE, "R4 clear restarts count", n, BASE);

    // R4 clear overrides a tick in the same cycle
    for (int k = 0; k < BASE - 1; k++) do_tick(r, w);
    @(negedge clk) begin tick = 1'b1; clr_cmd = 1'b1; end
    @(negedge clk) begin tick = 1'b0; clr_cmd = 1'b0; end
    chk(rst_req == 0, "R4 clear beats final tick", int'(rst_req), 0);
    measure(BASE + 4, n, r, w);
    chk(r && n == BASE, "R4 period after clear with tick", n, BASE);

    // R5 sleep gives wake, then awake again
    for (int k = 0; k < 7; k++) do_tick(r, w);
    pulse_sleep();
    chk(to_n == 1, "R6 flag after sleep", int'(to_n), 1);
    measure(BASE + 4, n, r, w);
    chk(w && !r && n == BASE, "R5 wake on sleep expiry", n, BASE);
    chk(to_n == 0, "R6 flag after wake", int'(to_n), 0);
    measure(BASE + 4, n, r, w);
    chk(r && !w && n == BASE, "R5 reset after wake", n, BASE);

    // R8 select change without clear
    ps_on = 1'b1; ps_sel = 3'd0;
    pulse_clr();
    ps_sel = 3'd3;
    measure(BASE * 8 + 4, n, r, w);
    chk(r && n == BASE, "R8 change ignored until clear", n, BASE);
    pulse_clr();
    measure(BASE * 8 + 4, n, r, w);
    chk(r && n == BASE * 8, "R8 change used after clear", n, BASE * 8);

    // R10 idle cycles without tick
    ps_on = 1'b0;
    pulse_clr();
    for (int k = 0; k < BASE - 1; k++) do_tick(r, w);
    r = 1'b0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (rst_req) r = 1'b1;
    end
    chk(r == 0, "R10 no advance without tick", int'(r), 0);
    do_tick(r, w);
    chk(r == 1, "R10 final tick expires", int'(r), 1);

    // R7 disabled
    pulse_clr();
    wdt_en = 1'b0;
    measure(BASE * 6, n, r, w);
    chk(!r && !w, "R7 disabled no request", int'({r, w}), 0);
    chk(to_n == 1, "R7 disabled flag", int'(to_n), 1);
    wdt_en = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule